// File: doc/BRIEF.md
# I/Q Phase Lookup Stage

This block turns blocks of quantized in-phase and quadrature samples into phase angles by table lookup. Each input word carries eight I/Q pairs. For every lane the I and Q codes are joined into one address, and that address reads a RAM that holds a precomputed arctangent. All eight phases come out together, along with one valid strobe. The angle values are computed by a host, not by the block. The host writes them into the table over a four-wire serial port (mode 0) before any measurement starts. The table is copied once per lane, so all eight lanes read in the same cycle. Every copy receives every write.

The block has two modes, held in a small state machine. In `MODE_LOAD` (the mode after reset) sample words are refused and the table may be written. A control frame with its enable bit set takes the transition LOAD→RUN. In `MODE_RUN` sample words are looked up and table writes are refused. A control frame with the enable bit clear takes the transition RUN→LOAD. The serial loader has four states. `LD_IDLE` goes to `LD_SHIFT` when chip select falls. `LD_SHIFT` goes to `LD_IDLE` when chip select rises early, or to `LD_COMMIT` on the last frame bit. `LD_COMMIT` always goes to `LD_DRAIN`. `LD_DRAIN` goes to `LD_IDLE` when chip select rises.

Sample and angle widths are parameters. The default sample width is 4 bits per component, giving a 256-entry table. The full-scale setting is 7 bits per component (a sign and six magnitude bits), giving 16384 entries per lane.

Top module: `phase_lut_top`

## Requirements
- R1: After reset, `phase_valid` is 0, `table_ready` is 0 and `phase_out` is all zeros.
- R2: Lane k (k = 0..7) reads the table at address {I_k, Q_k}. I_k is `samp_i[k*SAMP_W +: SAMP_W]` and Q_k is `samp_q[k*SAMP_W +: SAMP_W]`, with I in the upper bits. The entry read appears on `phase_out[k*PHASE_W +: PHASE_W]`.
- R3: All eight lanes are looked up in the same cycle from independent addresses, including addresses with the sign bit set and the all-zero and all-ones codes.
- R4: A word accepted with `samp_valid` in cycle t gives `phase_valid` = 1 with its data in cycle t+2 and nowhere else. Back-to-back words give back-to-back outputs.
- R5: A serial frame is 24 bits sent MSB first while `spi_cs_n` is low. `spi_mosi` is sampled on rising `spi_sclk`. The first 16 bits are an address and the last 8 bits are data. When address bit 15 is 0, the frame writes the data byte into every table copy at the address in the low 2*SAMP_W bits, once per frame. A table frame with any address bit between 2*SAMP_W and 14 set is dropped.
- R6: A frame with address bit 15 set is a control frame. Data bit 0 = 1 enters `MODE_RUN` (`table_ready` = 1). Data bit 0 = 0 returns to `MODE_LOAD`.
- R7: While `table_ready` is 0, `samp_valid` is ignored and `phase_valid` stays 0.
- R8: While `table_ready` is 1, table frames leave the table unchanged.
- R9: A frame cut off by `spi_cs_n` rising before its 24th bit writes nothing. Bits after the 24th, up to the rise of `spi_cs_n`, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host, oversampled by clk |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| samp_valid | input | 1 | Sample word present |
| samp_i | input | LANES*SAMP_W | Eight in-phase codes, lane 0 in the low bits |
| samp_q | input | LANES*SAMP_W | Eight quadrature codes, lane 0 in the low bits |
| phase_valid | output | 1 | Phase word present |
| phase_out | output | LANES*PHASE_W | Eight phase values, lane 0 in the low bits |
| table_ready | output | 1 | High in MODE_RUN |

## Verification
The bench goes after lanes being crossed or the I/Q halves swapped. It uses a per-lane pattern in which every lane carries a different address, plus the all-zero, all-ones and sign-only codes, so a swap would show up as wrong angles in some lanes. Latency is checked cycle by cycle, both for single words and for a back-to-back stream. A pipeline that is one stage short or one stage long would move the strobe or pair it with another word's data. The bench tries three ways to corrupt the table: a write while running, a frame cut short, and a frame with trailing extra bits. A design that let any of these through would show a changed angle on the next lookup. Samples sent before the enable frame must produce no strobe at all.

// File: rtl/phase_lut_pkg.sv
package phase_lut_pkg;
    localparam int SPI_ADDR_BITS = 16;
    localparam int SPI_DATA_BITS = 8;
    localparam int SPI_FRAME_BITS = SPI_ADDR_BITS + SPI_DATA_BITS;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_SHIFT,
        LD_COMMIT,
        LD_DRAIN
    } ld_state_t;

    typedef enum logic {
        MODE_LOAD,
        MODE_RUN
    } mode_t;
endpackage

// File: rtl/phase_spi_loader.sv
module phase_spi_loader
    import phase_lut_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk,
    input  logic                     cs_n,
    input  logic                     mosi,
    output logic                     wr_en,
    output logic [AW-1:0]            wr_addr,
    output logic [SPI_DATA_BITS-1:0] wr_data,
    output logic                     ctl_wr,
    output logic                     ctl_bit
);
    localparam int FB    = SPI_FRAME_BITS;
    localparam int CNT_W = $clog2(FB + 1);
    localparam int HI_LO = SPI_DATA_BITS + AW;
    localparam int HI_HI = FB - 2;

    logic [2:0]       sclk_sh;
    logic [1:0]       cs_sh;
    logic [1:0]       mosi_sh;
    logic             sclk_rise;
    logic             cs_hi;
    logic [FB-1:0]    frame_q;
    logic [CNT_W-1:0] cnt_q;
    ld_state_t        state_q, state_d;

    assign sclk_rise = sclk_sh[1] & ~sclk_sh[2];
    assign cs_hi     = cs_sh[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sh <= '0;
            cs_sh   <= '1;
            mosi_sh <= '0;
        end else begin
            sclk_sh <= {sclk_sh[1:0], sclk};
            cs_sh   <= {cs_sh[0], cs_n};
            mosi_sh <= {mosi_sh[0], mosi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:   if (!cs_hi) state_d = LD_SHIFT;
            LD_SHIFT:  if (cs_hi) state_d = LD_IDLE;
                       else if (sclk_rise && cnt_q == CNT_W'(FB - 1)) state_d = LD_COMMIT;
            LD_COMMIT: state_d = LD_DRAIN;
            LD_DRAIN:  if (cs_hi) state_d = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            cnt_q   <= '0;
        end else if (state_q == LD_IDLE) begin
            cnt_q <= '0;
        end else if (state_q == LD_SHIFT && sclk_rise) begin
            frame_q <= {frame_q[FB-2:0], mosi_sh[1]};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        wr_addr = frame_q[SPI_DATA_BITS +: AW];
        wr_data = frame_q[SPI_DATA_BITS-1:0];
        ctl_bit = frame_q[0];
        ctl_wr  = (state_q == LD_COMMIT) && frame_q[FB-1];
        wr_en   = (state_q == LD_COMMIT) && !frame_q[FB-1]
                  && (frame_q[HI_HI:HI_LO] == '0);
    end
endmodule

// File: rtl/phase_lane_ram.sv
module phase_lane_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/phase_lut_top.sv
module phase_lut_top
    import phase_lut_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int SAMP_W  = 4,
    parameter int PHASE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_sclk,
    input  logic                       spi_cs_n,
    input  logic                       spi_mosi,
    input  logic                       samp_valid,
    input  logic [LANES*SAMP_W-1:0]    samp_i,
    input  logic [LANES*SAMP_W-1:0]    samp_q,
    output logic                       phase_valid,
    output logic [LANES*PHASE_W-1:0]   phase_out,
    output logic                       table_ready
);
    localparam int AW = 2 * SAMP_W;

    logic                     wr_en, ctl_wr, ctl_bit;
    logic [AW-1:0]            wr_addr;
    logic [SPI_DATA_BITS-1:0] wr_data;
    logic                     tbl_we, accept;
    logic                     v1_q, v2_q;
    mode_t                    mode_q, mode_d;

    phase_spi_loader #(.AW(AW)) u_loader (
        .clk(clk), .rst_n(rst_n),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctl_wr(ctl_wr), .ctl_bit(ctl_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_LOAD;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_LOAD: if (ctl_wr && ctl_bit)  mode_d = MODE_RUN;
            MODE_RUN:  if (ctl_wr && !ctl_bit) mode_d = MODE_LOAD;
        endcase
    end

    always_comb begin
        table_ready = (mode_q == MODE_RUN);
        tbl_we      = wr_en && (mode_q == MODE_LOAD);
        accept      = samp_valid && (mode_q == MODE_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
        end else begin
            v1_q <= accept;
            v2_q <= v1_q;
        end
    end
    assign phase_valid = v2_q;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [AW-1:0] addr_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      addr_q <= '0;
            else if (accept) addr_q <= {samp_i[k*SAMP_W +: SAMP_W], samp_q[k*SAMP_W +: SAMP_W]};
        end

        phase_lane_ram #(.AW(AW), .DW(PHASE_W)) u_ram (
            .clk(clk), .rst_n(rst_n),
            .we(tbl_we), .waddr(wr_addr), .wdata(wr_data[PHASE_W-1:0]),
            .re(v1_q), .raddr(addr_q),
            .rdata(phase_out[k*PHASE_W +: PHASE_W])
        );
    end
endmodule

// File: rtl/phase_lut_chk.sv
module phase_lut_chk (
    input logic clk,
    input logic rst_n,
    input logic samp_valid,
    input logic table_ready,
    input logic phase_valid,
    input logic tbl_we,
    input logic ctl_wr,
    input logic ctl_bit
);
    // R4
    lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_valid |-> $past(samp_valid, 2));

    // R7
    blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && !table_ready) |=> ##1 !phase_valid);

    // R6
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(table_ready) |-> $past(ctl_wr && ctl_bit));

    // R5
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |=> !tbl_we);
endmodule

bind phase_lut_top phase_lut_chk u_phase_lut_chk (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid),
    .table_ready(table_ready), .phase_valid(phase_valid),
    .tbl_we(tbl_we), .ctl_wr(ctl_wr), .ctl_bit(ctl_bit)
);

// File: tb/test_phase_lut_top.sv
module test_phase_lut_top;
    localparam int LANES = 8;
    localparam int SW    = 4;
    localparam int PW    = 8;
    localparam int DEPTH = 1 << (2 * SW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic samp_valid = 1'b0;
    logic [LANES*SW-1:0] samp_i = '0, samp_q = '0;
    logic phase_valid, table_ready;
    logic [LANES*PW-1:0] phase_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [PW-1:0] model [DEPTH];

    always #10 clk = ~clk;

    phase_lut_top #(.LANES(LANES), .SAMP_W(SW), .PHASE_W(PW)) i_phase_lut_top (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .samp_valid(samp_valid), .samp_i(samp_i), .samp_q(samp_q),
        .phase_valid(phase_valid), .phase_out(phase_out), .table_ready(table_ready)
    );

    function automatic logic [PW-1:0] angle_of(int a);
        return PW'((a * 37 + 11) & 8'hFF);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_bits(input logic [23:0] w, input int nbits);
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            spi_mosi = (b < 24) ? w[23-b] : 1'b1;
            repeat (4) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (4) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic set_mode(input bit run);
        spi_bits({16'h8000, 7'd0, run}, 24);
    endtask

    function automatic logic [PW-1:0] lane_exp(input logic [LANES*SW-1:0] ii, input logic [LANES*SW-1:0] qq, input int k);
        return model[{ii[k*SW +: SW], qq[k*SW +: SW]}];
    endfunction

    // drive one word, verify strobe timing and all lanes
    task automatic lookup_word(input logic [LANES*SW-1:0] ii, input logic [LANES*SW-1:0] qq, input string req);
        @(negedge clk);
        samp_i = ii; samp_q = qq; samp_valid = 1'b1;
        @(negedge clk);
        samp_valid = 1'b0;
        check(phase_valid == 1'b0, "R4 early strobe", phase_valid, 0);
        @(negedge clk);
        check(phase_valid == 1'b1, "R4 strobe at t+2", phase_valid, 1);
        for (int k = 0; k < LANES; k++)
            check(phase_out[k*PW +: PW] == lane_exp(ii, qq, k), req,
                  phase_out[k*PW +: PW], lane_exp(ii, qq, k));
        @(negedge clk);
        check(phase_valid == 1'b0, "R4 single strobe", phase_valid, 0);
    endtask

    task automatic t_reset;
        check(phase_valid == 1'b0, "R1 valid", phase_valid, 0);
        check(table_ready == 1'b0, "R1 ready", table_ready, 0);
        check(phase_out == '0, "R1 phase", phase_out, 0);
    endtask

    task automatic t_blocked(input string req);
        @(negedge clk);
        samp_i = '1; samp_q = '1; samp_valid = 1'b1;
        @(negedge clk);
        samp_valid = 1'b0;
        for (int c = 0; c < 4; c++) begin
            check(phase_valid == 1'b0, req, phase_valid, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_load;
        for (int a = 0; a < DEPTH; a++) begin
            model[a] = angle_of(a);
            spi_bits({16'(a), angle_of(a)}, 24);
        end
        check(table_ready == 1'b0, "R6 still loading", table_ready, 0);
        set_mode(1'b1);
        check(table_ready == 1'b1, "R6 enable", table_ready, 1);
    endtask

    task automatic t_patterns;
        logic [LANES*SW-1:0] ii, qq;
        for (int k = 0; k < LANES; k++) begin
            ii[k*SW +: SW] = SW'(k);
            qq[k*SW +: SW] = SW'(15 - 2 * k);
        end
        lookup_word(ii, qq, "R2 lane pattern");
        lookup_word('0, '0, "R3 all zero");
        lookup_word('1, '1, "R3 all ones");
        for (int k = 0; k < LANES; k++) begin
            ii[k*SW +: SW] = (k % 2) ? 4'h8 : 4'h7;
            qq[k*SW +: SW] = (k % 2) ? 4'h7 : 4'h8;
        end
        lookup_word(ii, qq, "R3 sign codes");
    endtask

    task automatic t_stream;
        logic [LANES*SW-1:0] wi [3];
        logic [LANES*SW-1:0] wq [3];
        for (int w = 0; w < 3; w++)
            for (int k = 0; k < LANES; k++) begin
                wi[w][k*SW +: SW] = SW'(3 * w + k);
                wq[w][k*SW +: SW] = SW'(5 * k + w);
            end
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                check(phase_valid == 1'b1, "R4 stream strobe", phase_valid, 1);
                for (int k = 0; k < LANES; k++)
                    check(phase_out[k*PW +: PW] == lane_exp(wi[c-2], wq[c-2], k), "R4 stream data",
                          phase_out[k*PW +: PW], lane_exp(wi[c-2], wq[c-2], k));
            end
            if (c < 3) begin
                samp_i = wi[c]; samp_q = wq[c]; samp_valid = 1'b1;
            end else begin
                samp_valid = 1'b0;
            end
        end
        @(negedge clk);
        check(phase_valid == 1'b0, "R4 stream end", phase_valid, 0);
    endtask

    task automatic t_locked;
        spi_bits({16'h0023, 8'h00}, 24);
        lookup_word({28'd0, 4'h2}, {28'd0, 4'h3}, "R8 write while running");
    endtask

    task automatic t_frames;
        set_mode(1'b0);
        check(table_ready == 1'b0, "R6 disable", table_ready, 0);
        t_blocked("R7 after disable");
        spi_bits({16'h0023, 8'h55}, 12);
        spi_bits({16'h0057, 8'h44}, 24);
        model[8'h57] = 8'h44;
        spi_bits({16'h0031, 8'h66}, 30);
        model[8'h31] = 8'h66;
        spi_bits({16'h0140, 8'h99}, 24);
        set_mode(1'b1);
        lookup_word({28'd0, 4'h2}, {28'd0, 4'h3}, "R9 cut frame");
        lookup_word({28'd0, 4'h5}, {28'd0, 4'h7}, "R5 reload entry");
        lookup_word({28'd0, 4'h3}, {28'd0, 4'h1}, "R9 trailing bits");
        lookup_word({28'd0, 4'h4}, {28'd0, 4'h0}, "R5 high address dropped");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_blocked("R7 before load");
        t_load;
        t_patterns;
        t_stream;
        t_locked;
        t_frames;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule